// File: doc/BRIEF.md
# AC-link receive frame status capture

This block sits on the receive side of an AC97-style serial link. It aligns to the frame marker, splits each incoming 256-bit frame into its tag and twelve data slots, and extracts three things. The first is the codec register read-back carried in slots 1 and 2. The second is the 20-bit GPIO pin state the codec reports in slot 12. The third is one PCM receive word taken from either slot 6 or slot 11. It also raises a one-cycle interrupt request when a GPIO change or a fresh status read-back arrives, gated by enable bits.

The block runs on a single system clock. The falling edges of the serial bit clock arrive as a one-cycle sample strobe that a synchronizer has already produced upstream. The control bits come from a register block and are plain inputs here. The status fields are plain outputs that the register block can map for reads. A second serial data input can be merged into the first for codecs that share the receive path.

Top module: `aclink_rx_status`

## Requirements
- R1: A bit is taken only in a cycle where `bit_stb_i` is high. Frame bit 0 is the first sampled bit with `sync_i` high whose preceding sample had `sync_i` low. Bits sampled before the first such rise are ignored. A frame has 256 bits, sent MSB first. It starts with a 16-bit tag, where tag bit 15 is codec-ready and tag bit 15-n is the valid flag of slot n. Twelve 20-bit slots follow.
- R2: `stat_tag_o` is written at the last bit of slot 2 in every aligned frame. It becomes 1 when tag bits 15, 14 and 13 are all set, and 0 otherwise.
- R3: `stat_addr_o` takes slot 1 bits [19:12] and `stat_data_o` takes slot 2 bits [19:4]. Both update only in a frame that meets the R2 condition, and otherwise they hold.
- R4: When `gpio_if_en_i` is set at the last bit of slot 12, the GPIO fields respond to tag bit 3. If that bit is set, `gpio_stat_o` takes the slot 12 word and `gpio_nvalid_o` becomes 0. If it is clear, `gpio_stat_o` holds and `gpio_nvalid_o` becomes 1. When `gpio_if_en_i` is clear, neither field changes.
- R5: `rx_slot_sel_i` = 0 selects slot 6 and 1 selects slot 11. If the selected slot's tag bit is set, `rx_data_o` takes that slot's word and `rx_valid_o` pulses for one cycle. If the tag bit is clear, `rx_data_o` holds and no pulse occurs.
- R6: When `sdin2_en_i` is 0, `sdin2_i` has no effect. When it is 1, the serial data is the bitwise OR of `sdin_i` and `sdin2_i`.
- R7: `irq_o` pulses for one cycle when an R4 capture changes `gpio_stat_o`, but only if `gpio_if_en_i` and `gpio_irq_en_i` are both set.
- R8: `irq_o` pulses for one cycle on a frame meeting the R2 condition, but only if `ser_irq_en_i` is set.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bit_stb_i | input | 1 | one-cycle strobe at each falling bit-clock edge |
| sync_i | input | 1 | frame marker |
| sdin_i | input | 1 | primary serial data in |
| sdin2_i | input | 1 | secondary serial data in |
| sdin2_en_i | input | 1 | merge the secondary input |
| rx_slot_sel_i | input | 1 | receive slot: 0 = slot 6, 1 = slot 11 |
| gpio_if_en_i | input | 1 | GPIO status interface enable |
| gpio_irq_en_i | input | 1 | GPIO interrupt enable |
| ser_irq_en_i | input | 1 | status read-back interrupt enable |
| stat_addr_o | output | 8 | codec register address of the read-back |
| stat_data_o | output | 16 | codec register data of the read-back |
| stat_tag_o | output | 1 | read-back is fresh in the latest frame |
| gpio_stat_o | output | 20 | codec GPIO pin status |
| gpio_nvalid_o | output | 1 | 0 = GPIO status valid, 1 = not valid |
| rx_data_o | output | 20 | PCM receive word |
| rx_valid_o | output | 1 | one-cycle pulse when `rx_data_o` loads |
| irq_o | output | 1 | one-cycle interrupt request |

## Verification
The bench sends whole frames that differ in only one respect at a time. One frame has the marker held low throughout, which separates an aligned receiver from one that captures regardless. Other frames carry tags with exactly one of the three status bits dropped, which shows whether the freshness test uses all three flags. GPIO frames repeat a value, change it, drop its tag bit and then arrive with the interface disabled, which separates capture, invalid-flag and change-detection faults. Receive frames put different words in slots 6 and 11, and the secondary line carries disjoint bits, so a swapped slot select or a missing OR gate shows up in the data.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int SLOT_COUNT = 12;
  localparam int ADDR_BITS  = 8;
  localparam int DATA_BITS  = 16;

  localparam int SLOT_ADDR  = 1;
  localparam int SLOT_DATA  = 2;
  localparam int SLOT_RX_LO = 6;
  localparam int SLOT_RX_HI = 11;
  localparam int SLOT_GPIO  = 12;

  function automatic int slot_last_bit(input int tag_w, input int slot_w, input int slot);
    return tag_w - 1 + slot_w * slot;
  endfunction

  function automatic int slot_flag_pos(input int tag_w, input int slot);
    return tag_w - 1 - slot;
  endfunction

endpackage

// File: rtl/aclink_frame_align.sv
module aclink_frame_align #(
  parameter int FRAME_BITS = 256,
  localparam int IDX_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb_i,
  input  logic             sync_i,
  output logic             bit_vld_o,
  output logic [IDX_W-1:0] bit_idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             sync_q, sync_d;
  logic             aligned_q, aligned_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             rise;
  logic             at_end;

  always_comb begin
    rise      = bit_stb_i & sync_i & ~sync_q;
    at_end    = (cnt_q == LAST_IDX);
    bit_vld_o = bit_stb_i & (rise | (aligned_q & ~at_end));
    bit_idx_o = rise ? '0 : cnt_q + 1'b1;

    sync_d    = sync_q;
    aligned_d = aligned_q;
    cnt_d     = cnt_q;
    if (bit_stb_i) begin
      sync_d    = sync_i;
      aligned_d = rise | (aligned_q & ~at_end);
    end
    if (bit_vld_o) begin
      cnt_d = bit_idx_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      aligned_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      sync_q    <= sync_d;
      aligned_q <= aligned_d;
      cnt_q     <= cnt_d;
    end
  end

endmodule

// File: rtl/aclink_slot_deser.sv
module aclink_slot_deser #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              din_i,
  output logic [SLOT_W-1:0] word_o,
  output logic [TAG_W-1:0]  tag_o
);

  localparam logic [IDX_W-1:0] TAG_LAST = IDX_W'(TAG_W - 1);

  logic [SLOT_W-1:0] shift_q, shift_d;
  logic [TAG_W-1:0]  tag_q, tag_d;

  always_comb begin
    word_o  = {shift_q[SLOT_W-2:0], din_i};
    shift_d = shift_q;
    tag_d   = tag_q;
    if (bit_vld_i) begin
      shift_d = word_o;
      if (bit_idx_i == TAG_LAST) begin
        tag_d = word_o[TAG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      tag_q   <= '0;
    end else begin
      shift_q <= shift_d;
      tag_q   <= tag_d;
    end
  end

  assign tag_o = tag_q;

endmodule

// File: rtl/aclink_status_capture.sv
module aclink_status_capture
  import aclink_rx_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [SLOT_W-1:0] word_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              rx_slot_sel_i,
  input  logic              gpio_if_en_i,
  input  logic              gpio_irq_en_i,
  input  logic              ser_irq_en_i,
  output logic [ADDR_W-1:0] stat_addr_o,
  output logic [DATA_W-1:0] stat_data_o,
  output logic              stat_tag_o,
  output logic [SLOT_W-1:0] gpio_stat_o,
  output logic              gpio_nvalid_o,
  output logic [SLOT_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              irq_o
);

  localparam logic [IDX_W-1:0] END_ADDR = IDX_W'(slot_last_bit(TAG_W, SLOT_W, SLOT_ADDR));
  localparam logic [IDX_W-1:0] END_DATA = IDX_W'(slot_last_bit(TAG_W, SLOT_W, SLOT_DATA));
  localparam logic [IDX_W-1:0] END_RXLO = IDX_W'(slot_last_bit(TAG_W, SLOT_W, SLOT_RX_LO));
  localparam logic [IDX_W-1:0] END_RXHI = IDX_W'(slot_last_bit(TAG_W, SLOT_W, SLOT_RX_HI));
  localparam logic [IDX_W-1:0] END_GPIO = IDX_W'(slot_last_bit(TAG_W, SLOT_W, SLOT_GPIO));
  localparam int               FLG_RDY  = TAG_W - 1;
  localparam int               FLG_ADDR = slot_flag_pos(TAG_W, SLOT_ADDR);
  localparam int               FLG_DATA = slot_flag_pos(TAG_W, SLOT_DATA);
  localparam int               FLG_RXLO = slot_flag_pos(TAG_W, SLOT_RX_LO);
  localparam int               FLG_RXHI = slot_flag_pos(TAG_W, SLOT_RX_HI);
  localparam int               FLG_GPIO = slot_flag_pos(TAG_W, SLOT_GPIO);

  logic [SLOT_W-1:0] hold_q, hold_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              tag_q, tag_d;
  logic [SLOT_W-1:0] gpio_q, gpio_d;
  logic              nval_q, nval_d;
  logic [SLOT_W-1:0] rx_q, rx_d;
  logic              rxv_q, rxv_d;
  logic              irq_q, irq_d;
  logic              fresh;
  logic              stat_evt;
  logic              gpio_evt;
  logic [IDX_W-1:0]  rx_end;
  logic              rx_flag;

  always_comb begin
    hold_d   = hold_q;
    addr_d   = addr_q;
    data_d   = data_q;
    tag_d    = tag_q;
    gpio_d   = gpio_q;
    nval_d   = nval_q;
    rx_d     = rx_q;
    rxv_d    = 1'b0;
    stat_evt = 1'b0;
    gpio_evt = 1'b0;
    fresh    = tag_i[FLG_RDY] & tag_i[FLG_ADDR] & tag_i[FLG_DATA];
    rx_end   = rx_slot_sel_i ? END_RXHI : END_RXLO;
    rx_flag  = rx_slot_sel_i ? tag_i[FLG_RXHI] : tag_i[FLG_RXLO];

    if (bit_vld_i) begin
      if (bit_idx_i == END_ADDR) begin
        hold_d = word_i;
      end
      if (bit_idx_i == END_DATA) begin
        tag_d    = fresh;
        stat_evt = fresh;
        if (fresh) begin
          addr_d = hold_q[SLOT_W-1 -: ADDR_W];
          data_d = word_i[SLOT_W-1 -: DATA_W];
        end
      end
      if ((bit_idx_i == rx_end) && rx_flag) begin
        rx_d  = word_i;
        rxv_d = 1'b1;
      end
      if ((bit_idx_i == END_GPIO) && gpio_if_en_i) begin
        if (tag_i[FLG_GPIO]) begin
          gpio_d   = word_i;
          nval_d   = 1'b0;
          gpio_evt = (word_i != gpio_q);
        end else begin
          nval_d = 1'b1;
        end
      end
    end

    irq_d = (gpio_evt & gpio_if_en_i & gpio_irq_en_i) | (stat_evt & ser_irq_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      tag_q  <= 1'b0;
      gpio_q <= '0;
      nval_q <= 1'b0;
      rx_q   <= '0;
      rxv_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      addr_q <= addr_d;
      data_q <= data_d;
      tag_q  <= tag_d;
      gpio_q <= gpio_d;
      nval_q <= nval_d;
      rx_q   <= rx_d;
      rxv_q  <= rxv_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_addr_o   = addr_q;
  assign stat_data_o   = data_q;
  assign stat_tag_o    = tag_q;
  assign gpio_stat_o   = gpio_q;
  assign gpio_nvalid_o = nval_q;
  assign rx_data_o     = rx_q;
  assign rx_valid_o    = rxv_q;
  assign irq_o         = irq_q;

endmodule

// File: rtl/aclink_rx_status.sv
module aclink_rx_status
  import aclink_rx_pkg::*;
#(
  parameter int TAG_W  = TAG_BITS,
  parameter int SLOT_W = SLOT_BITS,
  parameter int NSLOT  = SLOT_COUNT,
  parameter int ADDR_W = ADDR_BITS,
  parameter int DATA_W = DATA_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              sync_i,
  input  logic              sdin_i,
  input  logic              sdin2_i,
  input  logic              sdin2_en_i,
  input  logic              rx_slot_sel_i,
  input  logic              gpio_if_en_i,
  input  logic              gpio_irq_en_i,
  input  logic              ser_irq_en_i,
  output logic [ADDR_W-1:0] stat_addr_o,
  output logic [DATA_W-1:0] stat_data_o,
  output logic              stat_tag_o,
  output logic [SLOT_W-1:0] gpio_stat_o,
  output logic              gpio_nvalid_o,
  output logic [SLOT_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              irq_o
);

  localparam int FRAME_BITS = TAG_W + SLOT_W * NSLOT;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  logic              bit_vld;
  logic [IDX_W-1:0]  bit_idx;
  logic              din;
  logic [SLOT_W-1:0] word;
  logic [TAG_W-1:0]  tag;

  assign din = sdin_i | (sdin2_i & sdin2_en_i);

  aclink_frame_align #(
    .FRAME_BITS (FRAME_BITS)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_i (bit_stb_i),
    .sync_i    (sync_i),
    .bit_vld_o (bit_vld),
    .bit_idx_o (bit_idx)
  );

  aclink_slot_deser #(
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W),
    .IDX_W  (IDX_W)
  ) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld_i (bit_vld),
    .bit_idx_i (bit_idx),
    .din_i     (din),
    .word_o    (word),
    .tag_o     (tag)
  );

  aclink_status_capture #(
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_vld_i     (bit_vld),
    .bit_idx_i     (bit_idx),
    .word_i        (word),
    .tag_i         (tag),
    .rx_slot_sel_i (rx_slot_sel_i),
    .gpio_if_en_i  (gpio_if_en_i),
    .gpio_irq_en_i (gpio_irq_en_i),
    .ser_irq_en_i  (ser_irq_en_i),
    .stat_addr_o   (stat_addr_o),
    .stat_data_o   (stat_data_o),
    .stat_tag_o    (stat_tag_o),
    .gpio_stat_o   (gpio_stat_o),
    .gpio_nvalid_o (gpio_nvalid_o),
    .rx_data_o     (rx_data_o),
    .rx_valid_o    (rx_valid_o),
    .irq_o         (irq_o)
  );

endmodule

// File: rtl/aclink_rx_status_chk.sv
module aclink_rx_status_chk #(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gpio_if_en_i,
  input logic              gpio_irq_en_i,
  input logic              ser_irq_en_i,
  input logic [ADDR_W-1:0] stat_addr_o,
  input logic [DATA_W-1:0] stat_data_o,
  input logic              stat_tag_o,
  input logic [SLOT_W-1:0] gpio_stat_o,
  input logic              gpio_nvalid_o,
  input logic [SLOT_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              irq_o
);

  // R3
  addr_needs_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_addr_o) |-> stat_tag_o);

  // R3
  data_needs_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_data_o) |-> stat_tag_o);

  // R4
  gpio_needs_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_stat_o) |-> ($past(gpio_if_en_i) && !gpio_nvalid_o));

  // R5
  rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R5
  rx_data_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data_o) |-> rx_valid_o);

  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(ser_irq_en_i) || ($past(gpio_if_en_i) && $past(gpio_irq_en_i))));

  // R8
  irq_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

endmodule

bind aclink_rx_status aclink_rx_status_chk #(
  .SLOT_W (SLOT_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gpio_if_en_i  (gpio_if_en_i),
  .gpio_irq_en_i (gpio_irq_en_i),
  .ser_irq_en_i  (ser_irq_en_i),
  .stat_addr_o   (stat_addr_o),
  .stat_data_o   (stat_data_o),
  .stat_tag_o    (stat_tag_o),
  .gpio_stat_o   (gpio_stat_o),
  .gpio_nvalid_o (gpio_nvalid_o),
  .rx_data_o     (rx_data_o),
  .rx_valid_o    (rx_valid_o),
  .irq_o         (irq_o)
);

// File: tb/aclink_rx_status_tb.sv
`timescale 1ns/1ps
module aclink_rx_status_tb;

  logic        clk;
  logic        rst_n;
  logic        bit_stb_i, sync_i, sdin_i, sdin2_i;
  logic        sdin2_en_i, rx_slot_sel_i, gpio_if_en_i, gpio_irq_en_i, ser_irq_en_i;
  logic [7:0]  stat_addr_o;
  logic [15:0] stat_data_o;
  logic        stat_tag_o;
  logic [19:0] gpio_stat_o;
  logic        gpio_nvalid_o;
  logic [19:0] rx_data_o;
  logic        rx_valid_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  int irq_cnt = 0;
  int rxv_cnt = 0;

  logic [15:0] ftag, ftag2;
  logic [19:0] fslot  [1:12];
  logic [19:0] fslot2 [1:12];

  aclink_rx_status u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_stb_i     (bit_stb_i),
    .sync_i        (sync_i),
    .sdin_i        (sdin_i),
    .sdin2_i       (sdin2_i),
    .sdin2_en_i    (sdin2_en_i),
    .rx_slot_sel_i (rx_slot_sel_i),
    .gpio_if_en_i  (gpio_if_en_i),
    .gpio_irq_en_i (gpio_irq_en_i),
    .ser_irq_en_i  (ser_irq_en_i),
    .stat_addr_o   (stat_addr_o),
    .stat_data_o   (stat_data_o),
    .stat_tag_o    (stat_tag_o),
    .gpio_stat_o   (gpio_stat_o),
    .gpio_nvalid_o (gpio_nvalid_o),
    .rx_data_o     (rx_data_o),
    .rx_valid_o    (rx_valid_o),
    .irq_o         (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (irq_o) irq_cnt++;
    if (rx_valid_o) rxv_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic frame_bit(input logic [15:0] t, input logic [19:0] s [1:12], input int b);
    int sl;
    int pos;
    if (b < 16) return t[15-b];
    sl  = (b - 16) / 20 + 1;
    pos = 19 - ((b - 16) % 20);
    return s[sl][pos];
  endfunction

  task automatic send_frame(input bit use_sync);
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      bit_stb_i = 1'b1;
      sync_i    = use_sync && (b < 16);
      sdin_i    = frame_bit(ftag, fslot, b);
      sdin2_i   = frame_bit(ftag2, fslot2, b);
      @(negedge clk);
      bit_stb_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic clear_frame();
    ftag  = 16'h0000;
    ftag2 = 16'h0000;
    for (int i = 1; i <= 12; i++) begin
      fslot[i]  = 20'h0;
      fslot2[i] = 20'h0;
    end
  endtask

  task automatic t_reset();
    check("R9 addr", {24'h0, stat_addr_o}, 32'h0);
    check("R9 data", {16'h0, stat_data_o}, 32'h0);
    check("R9 tag", {31'h0, stat_tag_o}, 32'h0);
    check("R9 gpio", {12'h0, gpio_stat_o}, 32'h0);
    check("R9 nvalid", {31'h0, gpio_nvalid_o}, 32'h0);
    check("R9 rx", {12'h0, rx_data_o}, 32'h0);
    check("R9 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_no_sync();
    clear_frame();
    ftag = 16'hFFF8;
    fslot[1] = 20'h77000;
    fslot[2] = 20'h12340;
    fslot[6] = 20'h5A5A5;
    rxv_cnt = 0;
    send_frame(1'b0);
    check("R1 no marker addr", {24'h0, stat_addr_o}, 32'h0);
    check("R1 no marker tag", {31'h0, stat_tag_o}, 32'h0);
    check("R1 no marker rx pulses", rxv_cnt, 0);
  endtask

  task automatic t_status_fresh();
    clear_frame();
    ftag = 16'hFFF8;
    fslot[1] = 20'hA5123;
    fslot[2] = 20'hBEEF0;
    irq_cnt = 0;
    send_frame(1'b1);
    check("R1 R3 addr", {24'h0, stat_addr_o}, 32'hA5);
    check("R3 data", {16'h0, stat_data_o}, 32'hBEEF);
    check("R2 tag fresh", {31'h0, stat_tag_o}, 32'h1);
    check("R8 no irq when disabled", irq_cnt, 0);
  endtask

  task automatic t_status_stale();
    clear_frame();
    fslot[1] = 20'h3C000;
    fslot[2] = 20'h11110;
    ftag = 16'hDFF8;
    send_frame(1'b1);
    check("R2 tag stale slot2", {31'h0, stat_tag_o}, 32'h0);
    check("R3 addr held", {24'h0, stat_addr_o}, 32'hA5);
    check("R3 data held", {16'h0, stat_data_o}, 32'hBEEF);
    ftag = 16'hBFF8;
    send_frame(1'b1);
    check("R2 tag stale slot1", {31'h0, stat_tag_o}, 32'h0);
    ftag = 16'h7FF8;
    send_frame(1'b1);
    check("R2 tag stale ready", {31'h0, stat_tag_o}, 32'h0);
    check("R3 data held again", {16'h0, stat_data_o}, 32'hBEEF);
  endtask

  task automatic t_gpio();
    clear_frame();
    ftag = 16'h0008;
    fslot[12] = 20'h12345;
    gpio_if_en_i = 1'b1;
    gpio_irq_en_i = 1'b0;
    irq_cnt = 0;
    send_frame(1'b1);
    check("R4 gpio captured", {12'h0, gpio_stat_o}, 32'h12345);
    check("R4 gpio valid", {31'h0, gpio_nvalid_o}, 32'h0);
    check("R7 no irq without irq enable", irq_cnt, 0);
    gpio_irq_en_i = 1'b1;
    send_frame(1'b1);
    check("R7 no irq on same value", irq_cnt, 0);
    fslot[12] = 20'h54321;
    send_frame(1'b1);
    check("R7 irq on change", irq_cnt, 1);
    check("R4 gpio new value", {12'h0, gpio_stat_o}, 32'h54321);
    ftag = 16'h0000;
    fslot[12] = 20'hFFFFF;
    irq_cnt = 0;
    send_frame(1'b1);
    check("R4 gpio invalid flag", {31'h0, gpio_nvalid_o}, 32'h1);
    check("R4 gpio held", {12'h0, gpio_stat_o}, 32'h54321);
    gpio_if_en_i = 1'b0;
    ftag = 16'h0008;
    fslot[12] = 20'h0ABCD;
    send_frame(1'b1);
    check("R4 gpio held when disabled", {12'h0, gpio_stat_o}, 32'h54321);
    check("R4 flag held when disabled", {31'h0, gpio_nvalid_o}, 32'h1);
    check("R7 no irq when interface off", irq_cnt, 0);
    gpio_irq_en_i = 1'b0;
  endtask

  task automatic t_rx_select();
    clear_frame();
    ftag = 16'h0230;
    fslot[6]  = 20'h66666;
    fslot[11] = 20'hBBBBB;
    rx_slot_sel_i = 1'b0;
    rxv_cnt = 0;
    send_frame(1'b1);
    check("R5 slot6 data", {12'h0, rx_data_o}, 32'h66666);
    check("R5 one pulse", rxv_cnt, 1);
    rx_slot_sel_i = 1'b1;
    send_frame(1'b1);
    check("R5 slot11 data", {12'h0, rx_data_o}, 32'hBBBBB);
    rx_slot_sel_i = 1'b0;
    ftag = 16'h0030;
    fslot[6] = 20'h00001;
    rxv_cnt = 0;
    send_frame(1'b1);
    check("R5 held without flag", {12'h0, rx_data_o}, 32'hBBBBB);
    check("R5 no pulse without flag", rxv_cnt, 0);
  endtask

  task automatic t_second_input();
    clear_frame();
    ftag = 16'h0030;
    fslot[11]  = 20'h0F0F0;
    fslot2[11] = 20'hF0000;
    ftag2 = 16'hE000;
    fslot2[1] = 20'hFF000;
    fslot2[2] = 20'hFFFF0;
    rx_slot_sel_i = 1'b1;
    sdin2_en_i = 1'b0;
    send_frame(1'b1);
    check("R6 ignored rx", {12'h0, rx_data_o}, 32'h0F0F0);
    check("R6 ignored tag", {31'h0, stat_tag_o}, 32'h0);
    check("R6 ignored addr", {24'h0, stat_addr_o}, 32'hA5);
    sdin2_en_i = 1'b1;
    send_frame(1'b1);
    check("R6 merged rx", {12'h0, rx_data_o}, 32'hFF0F0);
    check("R6 merged tag", {31'h0, stat_tag_o}, 32'h1);
    check("R6 merged addr", {24'h0, stat_addr_o}, 32'hFF);
    sdin2_en_i = 1'b0;
    rx_slot_sel_i = 1'b0;
  endtask

  task automatic t_serial_irq();
    clear_frame();
    ftag = 16'hE000;
    fslot[1] = 20'h42000;
    fslot[2] = 20'h99990;
    ser_irq_en_i = 1'b1;
    irq_cnt = 0;
    send_frame(1'b1);
    check("R8 irq on fresh status", irq_cnt, 1);
    ftag = 16'hC000;
    irq_cnt = 0;
    send_frame(1'b1);
    check("R8 no irq on stale status", irq_cnt, 0);
    ser_irq_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bit_stb_i = 1'b0; sync_i = 1'b0; sdin_i = 1'b0; sdin2_i = 1'b0;
    sdin2_en_i = 1'b0; rx_slot_sel_i = 1'b0;
    gpio_if_en_i = 1'b0; gpio_irq_en_i = 1'b0; ser_irq_en_i = 1'b0;
    clear_frame();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_sync();
    t_status_fresh();
    t_status_stale();
    t_gpio();
    t_rx_select();
    t_second_input();
    t_serial_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule